// File: doc/BRIEF.md
# Serial Configuration Write Port

This block receives write-only configuration traffic over a three-wire serial link and uses it to fill a small bank of 10-bit control registers. The three wires are a serial clock, a serial data line and an active-low select. While the select is low, each active serial-clock edge shifts one data bit in, most significant bit first. A frame is 16 bits long. When the sixteenth bit arrives, the frame is decoded and the register it addresses is written. A static polarity pin chooses which serial-clock edge is the active one.

All serial pins are sampled in the host clock domain through a synchronizer chain. Edge detection happens after that chain. The register bank therefore changes only on host clock edges and has a fixed latency from the pins.

Register 0 is the control register. Its bit 0 requests power-down. Its bit 1 is a self-clearing request that returns the whole bank to its defaults. An active-low hardware reset does the same thing at any time. A power-down output is driven from the standby pin and from the control bit, and writes are still accepted while it is high.

Top module: `serial_cfg_port`

## Requirements
- R1: A frame is 16 bits, shifted in MSB first. Bits 15..14 carry no meaning and their values are ignored. Bits 13..10 are the register address and bits 9..0 are the data. The addressed register takes the data on the 3rd host clock edge after the pin change that makes the 16th active serial edge, and it is unchanged after the 2nd.
- R2: If the select rises after fewer than 16 active edges, the frame is discarded and no register changes. The bit count restarts at zero, so the next frame is decoded normally.
- R3: When the polarity pin is 1, bits are sampled on rising serial-clock edges. When it is 0, bits are sampled on falling edges.
- R4: Serial-clock and data activity while the select is high changes no register.
- R5: A frame whose address is NUM_REGS or above (8 to 15 by default) changes no register.
- R6: While the hardware reset input is low, every register holds its default. The default is 0 for register 0 and i*64+16 for register i>0.
- R7: A frame that writes register 0 with bit 1 set shows the written value for exactly one host cycle. After that, every register, including register 0, returns to its default.
- R8: The power-down output is high when the standby pin is low or when bit 0 of register 0 is set. It follows a standby pin change on the 2nd host clock edge. Register writes are still accepted while it is high.
- R9: Active edges after the 16th, within the same select-low window, are ignored. No second write happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data, MSB first |
| cs_n | input | 1 | Active-low serial select |
| sclk_pol | input | 1 | Active-edge select: 1 rising, 0 falling |
| stby_n | input | 1 | Active-low standby request |
| cfg_q | output | NUM_REGS*10 | Register bank, register i at bits [i*10+9:i*10] |
| pwr_down | output | 1 | Power-down status |

## Verification
Every pin passes through two synchronizer flops. A register therefore takes new data on the third host edge after the final active serial edge. The software-reset clear follows one edge after that, and the power-down output follows the standby pin on the second edge. The latency test drives the last serial edge on a falling host edge and samples the register on the falling edges after the second and third rising edges, which confirms both the old and the new value. Every other check waits several host cycles beyond the due cycle before sampling. Another check counts the host cycles in which control bit 1 reads back as set, so the one-cycle window of the software reset is measured exactly.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam int FRAME_BITS  = 16;
  localparam int ADDR_BITS   = 4;
  localparam int DATA_BITS   = 10;
  localparam int CNT_W       = $clog2(FRAME_BITS + 1);
  localparam int PD_BIT      = 0;
  localparam int SWRST_BIT   = 1;

  typedef struct packed {
    logic [ADDR_BITS-1:0] addr;
    logic [DATA_BITS-1:0] data;
  } cfg_wr_t;

  // Reset value of register idx: control register clears, others get a marker.
  function automatic logic [DATA_BITS-1:0] cfg_default(input int idx);
    if (idx == 0) return '0;
    return DATA_BITS'(idx * 64 + 16);
  endfunction

  // Split a complete frame into its address and data fields.
  function automatic cfg_wr_t frame_decode(input logic [FRAME_BITS-1:0] f);
    cfg_wr_t w;
    w.addr = f[DATA_BITS +: ADDR_BITS];
    w.data = f[DATA_BITS-1:0];
    return w;
  endfunction

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int              WIDTH     = 1,
  parameter int              STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      chain[s] <= RESET_VAL;
        else if (s == 0) chain[s] <= d;
        else             chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/scp_shifter.sv
module scp_shifter
  import scp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_s,
  input  logic             sdin_s,
  input  logic             cs_n_s,
  input  logic             pol_s,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             wr_stb,
  output cfg_wr_t          wr
);
  logic                  sclk_p;
  logic [FRAME_BITS-2:0] shreg;
  logic [FRAME_BITS-1:0] frame_word;
  logic                  act_edge;

  // Active edge: serial clock moved to the level named by the polarity pin.
  assign act_edge   = (sclk_s != sclk_p) && (sclk_s == pol_s) && !cs_n_s;
  assign frame_word = {shreg, sdin_s};
  assign wr_stb     = act_edge && (bit_cnt == CNT_W'(FRAME_BITS - 1));
  assign wr         = frame_decode(frame_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p  <= 1'b0;
      shreg   <= '0;
      bit_cnt <= '0;
    end else begin
      sclk_p <= sclk_s;
      if (cs_n_s) begin
        bit_cnt <= '0;
      end else if (act_edge && (bit_cnt < CNT_W'(FRAME_BITS))) begin
        shreg   <= frame_word[FRAME_BITS-2:0];
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scp_regbank.sv
module scp_regbank
  import scp_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_stb,
  input  cfg_wr_t                       wr,
  input  logic                          stby_n_s,
  output logic [NUM_REGS*DATA_BITS-1:0] cfg_q,
  output logic                          swrst,
  output logic                          pwr_down
);
  logic [DATA_BITS-1:0] regs [NUM_REGS];

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    regs[g] <= cfg_default(g);
        else if (swrst)                                regs[g] <= cfg_default(g);
        else if (wr_stb && wr.addr == ADDR_BITS'(g))   regs[g] <= wr.data;
      end
      assign cfg_q[g*DATA_BITS +: DATA_BITS] = regs[g];
    end
  endgenerate

  // One-cycle software reset request following a control write with bit set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) swrst <= 1'b0;
    else        swrst <= !swrst && wr_stb && (wr.addr == '0) && wr.data[SWRST_BIT];
  end

  assign pwr_down = !stby_n_s || regs[0][PD_BIT];
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import scp_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sclk,
  input  logic                          sdin,
  input  logic                          cs_n,
  input  logic                          sclk_pol,
  input  logic                          stby_n,
  output logic [NUM_REGS*DATA_BITS-1:0] cfg_q,
  output logic                          pwr_down
);
  logic             sclk_s, sdin_s, cs_n_s, pol_s, stby_n_s;
  logic [CNT_W-1:0] bit_cnt;
  logic             wr_stb;
  cfg_wr_t          wr;
  logic             swrst;
  logic [ADDR_BITS-1:0] wr_addr;
  logic [DATA_BITS-1:0] wr_data;

  scp_sync #(
    .WIDTH    (5),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(5'b11100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sclk_pol, stby_n, cs_n, sdin, sclk}),
    .q    ({pol_s, stby_n_s, cs_n_s, sdin_s, sclk_s})
  );

  scp_shifter u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_s (sclk_s),
    .sdin_s (sdin_s),
    .cs_n_s (cs_n_s),
    .pol_s  (pol_s),
    .bit_cnt(bit_cnt),
    .wr_stb (wr_stb),
    .wr     (wr)
  );

  scp_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr      (wr),
    .stby_n_s(stby_n_s),
    .cfg_q   (cfg_q),
    .swrst   (swrst),
    .pwr_down(pwr_down)
  );

  assign wr_addr = wr.addr;
  assign wr_data = wr.data;
endmodule

// File: rtl/scp_chk.sv
module scp_chk
  import scp_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cs_n_s,
  input logic                          stby_n_s,
  input logic [CNT_W-1:0]              bit_cnt,
  input logic                          wr_stb,
  input logic [ADDR_BITS-1:0]          wr_addr,
  input logic [DATA_BITS-1:0]          wr_data,
  input logic                          swrst,
  input logic [NUM_REGS*DATA_BITS-1:0] cfg_q,
  input logic                          pwr_down
);
  function automatic logic [NUM_REGS*DATA_BITS-1:0] all_defaults();
    logic [NUM_REGS*DATA_BITS-1:0] v;
    for (int i = 0; i < NUM_REGS; i++) v[i*DATA_BITS +: DATA_BITS] = cfg_default(i);
    return v;
  endfunction

  localparam logic [NUM_REGS*DATA_BITS-1:0] DEFAULTS = all_defaults();

  a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_BITS));

  a_r2_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> bit_cnt == '0);

  a_r4_no_write_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |-> !wr_stb);

  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr < NUM_REGS) |=> cfg_q[$past(wr_addr)*DATA_BITS +: DATA_BITS] == $past(wr_data));

  a_r1_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !swrst) |=> $stable(cfg_q));

  a_r5_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr >= NUM_REGS && !swrst) |=> $stable(cfg_q));

  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    swrst |=> !swrst);

  a_r7_defaults_restored: assert property (@(posedge clk) disable iff (!rst_n)
    swrst |=> cfg_q == DEFAULTS);

  a_r8_standby_forces: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_n_s |-> pwr_down);
endmodule

bind serial_cfg_port scp_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n_s  (cs_n_s),
  .stby_n_s(stby_n_s),
  .bit_cnt (bit_cnt),
  .wr_stb  (wr_stb),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .swrst   (swrst),
  .cfg_q   (cfg_q),
  .pwr_down(pwr_down)
);

// File: tb/serial_cfg_port_tb.sv
`timescale 1ns/1ps
module serial_cfg_port_tb;
  localparam int NR = 8;
  localparam int DW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdin = 1'b0, cs_n = 1'b1, sclk_pol = 1'b1, stby_n = 1'b1;
  logic [NR*DW-1:0] cfg_q;
  logic pwr_down;

  int n_checks = 0;
  int n_fail   = 0;
  int swr_seen = 0;
  logic [DW-1:0] exp_r [NR];

  always #5 clk = ~clk;

  serial_cfg_port #(.NUM_REGS(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .cs_n(cs_n),
    .sclk_pol(sclk_pol), .stby_n(stby_n), .cfg_q(cfg_q), .pwr_down(pwr_down)
  );

  always @(negedge clk) if (rst_n && cfg_q[1]) swr_seen++;

  function automatic logic [DW-1:0] dflt(input int i);
    return (i == 0) ? 10'd0 : DW'((i << 6) + 16);
  endfunction

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finish_up();
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < NR; i++) check(req, 32'(cfg_q[i*DW +: DW]), 32'(exp_r[i]));
  endtask

  task automatic load_defaults();
    for (int i = 0; i < NR; i++) exp_r[i] = dflt(i);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One serial bit: data set in idle phase, then active edge, then back to idle.
  task automatic clock_bit(input logic b);
    sdin = b;
    wait_n(4);
    sclk = sclk_pol;
    wait_n(4);
    sclk = ~sclk_pol;
  endtask

  task automatic send_bits(input logic [31:0] w, input int nbits);
    @(negedge clk);
    sclk = ~sclk_pol;
    wait_n(4);
    cs_n = 1'b0;
    wait_n(4);
    for (int i = nbits - 1; i >= 0; i--) clock_bit(w[i]);
    wait_n(4);
    cs_n = 1'b1;
    wait_n(8);
  endtask

  function automatic logic [15:0] frame(input logic [1:0] nul, input logic [3:0] a, input logic [9:0] d);
    return {nul, a, d};
  endfunction

  task automatic t_reset();
    load_defaults();
    check_bank("R6 reset defaults");
    check("R8 no power-down after reset", 32'(pwr_down), 32'd0);
  endtask

  task automatic t_basic();
    send_bits(32'(frame(2'b00, 4'd3, 10'h2A5)), 16);
    exp_r[3] = 10'h2A5;
    check_bank("R1 write reg3 rising");
    send_bits(32'(frame(2'b11, 4'd5, 10'h155)), 16);
    exp_r[5] = 10'h155;
    check_bank("R1 null bits ignored");
  endtask

  task automatic t_latency();
    logic [15:0] f;
    f = frame(2'b00, 4'd7, 10'h0F0);
    @(negedge clk);
    sclk = ~sclk_pol;
    wait_n(4);
    cs_n = 1'b0;
    wait_n(4);
    for (int i = 15; i >= 1; i--) clock_bit(f[i]);
    sdin = f[0];
    wait_n(4);
    sclk = sclk_pol;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R1 latency old after 2 edges", 32'(cfg_q[7*DW +: DW]), 32'(exp_r[7]));
    @(posedge clk); @(negedge clk);
    exp_r[7] = 10'h0F0;
    check("R1 latency new after 3 edges", 32'(cfg_q[7*DW +: DW]), 32'(exp_r[7]));
    wait_n(4);
    sclk = ~sclk_pol;
    wait_n(4);
    cs_n = 1'b1;
    wait_n(8);
  endtask

  task automatic t_polarity();
    @(negedge clk);
    sclk_pol = 1'b0;
    sclk = 1'b1;
    wait_n(6);
    send_bits(32'(frame(2'b00, 4'd6, 10'h3C3)), 16);
    exp_r[6] = 10'h3C3;
    check_bank("R3 falling-edge write");
    @(negedge clk);
    sclk_pol = 1'b1;
    sclk = 1'b0;
    wait_n(6);
    send_bits(32'(frame(2'b00, 4'd6, 10'h01E)), 16);
    exp_r[6] = 10'h01E;
    check_bank("R3 rising-edge write");
  endtask

  task automatic t_short();
    send_bits(32'(frame(2'b00, 4'd2, 10'h3FF)) >> 6, 10);
    check_bank("R2 short frame discarded");
    send_bits(32'(frame(2'b00, 4'd2, 10'h011)), 16);
    exp_r[2] = 10'h011;
    check_bank("R2 count restarted");
  endtask

  task automatic t_deselected();
    for (int i = 0; i < 20; i++) begin
      sdin = i[0];
      wait_n(3);
      sclk = ~sclk;
      wait_n(3);
    end
    sclk = 1'b0;
    wait_n(6);
    check_bank("R4 activity while deselected");
    send_bits(32'(frame(2'b00, 4'd1, 10'h2BC)), 16);
    exp_r[1] = 10'h2BC;
    check_bank("R4 next frame normal");
  endtask

  task automatic t_unmapped();
    send_bits(32'(frame(2'b00, 4'd9, 10'h123)), 16);
    send_bits(32'(frame(2'b00, 4'd15, 10'h3AA)), 16);
    check_bank("R5 unmapped addresses ignored");
  endtask

  task automatic t_extra();
    send_bits({frame(2'b00, 4'd4, 10'h099), 4'b1011}, 20);
    exp_r[4] = 10'h099;
    check_bank("R9 trailing bits ignored");
  endtask

  task automatic t_powerdown();
    @(negedge clk);
    stby_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R8 standby not yet seen", 32'(pwr_down), 32'd0);
    @(posedge clk); @(negedge clk);
    check("R8 standby asserts power-down", 32'(pwr_down), 32'd1);
    send_bits(32'(frame(2'b00, 4'd4, 10'h1E1)), 16);
    exp_r[4] = 10'h1E1;
    check_bank("R8 write during power-down");
    stby_n = 1'b1;
    wait_n(4);
    check("R8 standby released", 32'(pwr_down), 32'd0);
    send_bits(32'(frame(2'b00, 4'd0, 10'h001)), 16);
    exp_r[0] = 10'h001;
    check("R8 control bit power-down", 32'(pwr_down), 32'd1);
    send_bits(32'(frame(2'b00, 4'd0, 10'h000)), 16);
    exp_r[0] = 10'h000;
    check("R8 control bit cleared", 32'(pwr_down), 32'd0);
  endtask

  task automatic t_swreset();
    swr_seen = 0;
    send_bits(32'(frame(2'b00, 4'd0, 10'h002)), 16);
    load_defaults();
    check_bank("R7 bank back to defaults");
    check("R7 reset bit visible one cycle", 32'(swr_seen), 32'd1);
  endtask

  task automatic t_hwreset();
    send_bits(32'(frame(2'b00, 4'd3, 10'h3F0)), 16);
    exp_r[3] = 10'h3F0;
    check_bank("R1 write before hw reset");
    @(negedge clk);
    rst_n = 1'b0;
    wait_n(3);
    load_defaults();
    check_bank("R6 hw reset restores defaults");
    rst_n = 1'b1;
    wait_n(4);
  endtask

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);
    t_reset();
    t_basic();
    t_latency();
    t_polarity();
    t_short();
    t_deselected();
    t_unmapped();
    t_extra();
    t_powerdown();
    t_swreset();
    t_hwreset();
    finish_up();
  end
endmodule